// File: doc/BRIEF.md
# Wait-State Bus Subordinate

This block is a memory-mapped subordinate on a single-manager AHB-Lite bus. It holds a small word-organised store built from registers. A parameter sets its access latency, which lets it stand in for a slow device on the bus. It sets the pace of its own transfers with a local ready output. It stays in step with the shared two-stage pipeline by watching the bus-wide ready input that the interconnect returns to every subordinate.

An address phase is registered only when the subordinate is selected, the transfer type is active and the incoming bus ready is high. The registered phase then becomes this block's data phase. For the first configured number of cycles of that data phase the local ready is held low. It rises on the following cycle, and write data is committed or read data is presented in that cycle. Outside a data phase the local ready stays high, so idle or unselected cycles never hold the bus.

Top module: `ahb_wait_sub`

## Requirements
- R1: After reset the local ready output is high, the response is OKAY (0) and the read data bus is zero.
- R2: A data phase that starts from an accepted address phase keeps the local ready low for exactly WAIT_N cycles and raises it on cycle WAIT_N+1. With WAIT_N=0 it completes with no wait.
- R3: An address phase is captured only when the incoming bus ready is high. A selected, active request seen while the bus ready is low starts no data phase and writes nothing.
- R4: A cycle with transfer type IDLE (0) or BUSY (1), or with the select low, starts no data phase and writes nothing. The local ready stays high during it and after it.
- R5: Write data is taken from the write data bus in the data-phase cycle where the local ready is high. A later read of that word returns it in its own completing cycle.
- R6: Transfer size 0 writes one byte, size 1 a halfword and size 2 a word. Byte lane k is bits 8k+7..8k, selected little-endian by the low address bits. Lanes outside the transfer keep their value.
- R7: The response output is OKAY (0) in every cycle.
- R8: The read data bus is zero in every cycle where the local ready is low.
- R9: A new address phase presented in the completing cycle of a data phase is accepted there. Its data phase follows at once, and a read of the word just written returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Subordinate select from the address decoder |
| haddr | input | ADDR_W | Byte address of the address phase |
| htrans | input | 2 | Transfer type: 0 idle, 1 busy, 2 nonsequential, 3 sequential |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready returned by the interconnect |
| hrdata | output | DATA_W | Read data, valid in the completing cycle |
| hreadyout | output | 1 | This subordinate's own ready |
| hresp | output | 1 | Transfer response, always OKAY |

## Verification
The bench builds the block with WAIT_N=3 and a 16-word store. Three wait cycles let it count the exact stall length and check that read data stays quiet during the stall. Sixteen words are enough that random traffic returns to the same words often, so merges of partial writes and read-after-write are exercised. The bench plays the interconnect role. It returns the block's own ready as the bus ready, and it can force the bus ready low to imitate another subordinate that is stalled. That makes the case of a rejected request observable.

// File: rtl/ahb_wait_pkg.sv
package ahb_wait_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  localparam logic RESP_OKAY = 1'b0;

  function automatic logic trans_active(input trans_e t);
    return (t == TR_NONSEQ) || (t == TR_SEQ);
  endfunction

endpackage

// File: rtl/ahb_wait_capture.sv
module ahb_wait_capture
  import ahb_wait_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LOC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel_i,
  input  trans_e            trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hready_i,
  input  logic              done_i,
  output logic              start_o,
  output logic              dp_valid_o,
  output logic              dp_write_o,
  output logic [2:0]        dp_size_o,
  output logic [LOC_W-1:0]  dp_addr_o
);

  logic             valid_q, valid_d;
  logic             write_q, write_d;
  logic [2:0]       size_q, size_d;
  logic [LOC_W-1:0] addr_q, addr_d;
  logic             accept;

  // The bus-wide ready, never the local one, decides sampling.
  assign accept = hsel_i && trans_active(trans_i) && hready_i;

  always_comb begin
    valid_d = valid_q;
    write_d = write_q;
    size_d  = size_q;
    addr_d  = addr_q;
    if (accept) begin
      valid_d = 1'b1;
      write_d = write_i;
      size_d  = size_i;
      addr_d  = addr_i[LOC_W-1:0];
    end else if (done_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      size_q  <= 3'd0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (accept) begin
        write_q <= write_d;
        size_q  <= size_d;
        addr_q  <= addr_d;
      end
    end
  end

  assign start_o    = accept;
  assign dp_valid_o = valid_q;
  assign dp_write_o = write_q;
  assign dp_size_o  = size_q;
  assign dp_addr_o  = addr_q;

  // R3: a low bus ready blocks capture while no data phase is open
  assert_no_capture_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready_i && !valid_q) |=> !valid_q);

  // R4: an idle, busy or unselected cycle opens no data phase
  assert_no_capture_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !(hsel_i && trans_active(trans_i))) |=> !valid_q);

endmodule

// File: rtl/ahb_wait_pacer.sv
module ahb_wait_pacer #(
  parameter int WAIT_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic dp_valid_i,
  output logic ready_o
);

  generate
    if (WAIT_N == 0) begin : g_nowait
      assign ready_o = 1'b1;

      // R2: zero waits completes in the first data cycle
      assert_zero_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ready_o);
    end else begin : g_count
      localparam int CNT_W = (WAIT_N < 2) ? 1 : $clog2(WAIT_N + 1);
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_N);

      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
        if (start_i) begin
          cnt_en = 1'b1;
          cnt_d  = LOAD;
        end else if (dp_valid_i && (cnt_q != '0)) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end

      assign ready_o = !dp_valid_i || (cnt_q == '0);

      // R2: the first data cycle after acceptance is a wait cycle
      assert_first_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !ready_o);

      // R2: a wait cycle with more than one wait left is followed by another
      assert_wait_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid_i && cnt_q > 1 && !start_i) |=> !ready_o);

      // R2: the counter never exceeds the configured wait count
      assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
    end
  endgenerate

endmodule

// File: rtl/ahb_wait_store.sv
module ahb_wait_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     wr_en_i,
  input  logic                                     rd_en_i,
  input  logic [$clog2(DEPTH)+$clog2(DATA_W/8)-1:0] addr_i,
  input  logic [2:0]                               size_i,
  input  logic [DATA_W-1:0]                        wdata_i,
  output logic [DATA_W-1:0]                        rdata_o
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFS_W = $clog2(BYTES);
  localparam int IDX_W = $clog2(DEPTH);

  logic [OFS_W-1:0]  ofs;
  logic [IDX_W-1:0]  idx;
  logic [BYTES-1:0]  lane_en;
  logic [DATA_W-1:0] words [DEPTH];

  assign ofs = addr_i[OFS_W-1:0];
  assign idx = addr_i[OFS_W +: IDX_W];

  always_comb begin
    int span;
    span = 1 << size_i;
    for (int b = 0; b < BYTES; b++) begin
      lane_en[b] = (b >= int'(ofs)) && (b < int'(ofs) + span);
    end
  end

  generate
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic              sel;

      assign sel = wr_en_i && (idx == IDX_W'(w));

      for (genvar b = 0; b < BYTES; b++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            word_q[8*b +: 8] <= 8'h00;
          end else if (sel && lane_en[b]) begin
            word_q[8*b +: 8] <= wdata_i[8*b +: 8];
          end
        end
      end

      assign words[w] = word_q;
    end
  endgenerate

  assign rdata_o = rd_en_i ? words[idx] : '0;

  // R8: no data leaves the store unless a read completes
  assert_rdata_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> (rdata_o == '0));

endmodule

// File: rtl/ahb_wait_sub.sv
module ahb_wait_sub
  import ahb_wait_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int WAIT_N = 2
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  output logic [DATA_W-1:0] hrdata,
  output logic              hreadyout,
  output logic              hresp
);

  localparam int LOC_W = $clog2(DEPTH) + $clog2(DATA_W / 8);

  logic             start;
  logic             dp_valid;
  logic             dp_write;
  logic [2:0]       dp_size;
  logic [LOC_W-1:0] dp_addr;
  logic             pace_ready;
  logic             done;
  trans_e           trans;

  assign trans = trans_e'(htrans);
  assign done  = dp_valid && pace_ready;

  ahb_wait_capture #(
    .ADDR_W (ADDR_W),
    .LOC_W  (LOC_W)
  ) u_capture (
    .clk        (hclk),
    .rst_n      (hresetn),
    .hsel_i     (hsel),
    .trans_i    (trans),
    .write_i    (hwrite),
    .size_i     (hsize),
    .addr_i     (haddr),
    .hready_i   (hready),
    .done_i     (done),
    .start_o    (start),
    .dp_valid_o (dp_valid),
    .dp_write_o (dp_write),
    .dp_size_o  (dp_size),
    .dp_addr_o  (dp_addr)
  );

  ahb_wait_pacer #(
    .WAIT_N (WAIT_N)
  ) u_pacer (
    .clk        (hclk),
    .rst_n      (hresetn),
    .start_i    (start),
    .dp_valid_i (dp_valid),
    .ready_o    (pace_ready)
  );

  ahb_wait_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk     (hclk),
    .rst_n   (hresetn),
    .wr_en_i (done && dp_write),
    .rd_en_i (done && !dp_write),
    .addr_i  (dp_addr),
    .size_i  (dp_size),
    .wdata_i (hwdata),
    .rdata_o (hrdata)
  );

  assign hreadyout = pace_ready;
  assign hresp     = RESP_OKAY;

  // R7: response stays OKAY
  assert_resp_okay_R7: assert property (@(posedge hclk) disable iff (!hresetn)
    hresp == 1'b0);

  // R8: a stalled cycle carries no read data
  assert_quiet_while_wait_R8: assert property (@(posedge hclk) disable iff (!hresetn)
    !hreadyout |-> (hrdata == '0));

  // R4: without an open data phase the subordinate never stalls
  assert_ready_when_free_R4: assert property (@(posedge hclk) disable iff (!hresetn)
    !dp_valid |-> hreadyout);

endmodule

// File: tb/ahb_wait_sub_tb.sv
module ahb_wait_sub_tb;

  localparam int WAIT_N = 3;
  localparam int DEPTH  = 16;

  logic        hclk = 1'b0;
  logic        hresetn;
  logic        hsel;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [31:0] hwdata;
  logic        other_stall;
  logic        bus_ready;
  logic [31:0] hrdata;
  logic        hreadyout;
  logic        hresp;

  int total = 0;
  int bad   = 0;
  logic [31:0] model [DEPTH];

  always #5 hclk = ~hclk;

  // Bench acts as interconnect: bus ready follows this subordinate unless another stalls.
  assign bus_ready = hreadyout && !other_stall;

  ahb_wait_sub #(
    .ADDR_W (32), .DATA_W (32), .DEPTH (DEPTH), .WAIT_N (WAIT_N)
  ) u_dut (
    .hclk (hclk), .hresetn (hresetn), .hsel (hsel), .haddr (haddr),
    .htrans (htrans), .hwrite (hwrite), .hsize (hsize), .hwdata (hwdata),
    .hready (bus_ready), .hrdata (hrdata), .hreadyout (hreadyout), .hresp (hresp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [5:0] a, input logic [2:0] sz);
    logic [31:0] r;
    int span;
    r = old;
    span = 1 << sz;
    for (int b = 0; b < 4; b++)
      if (b >= int'(a[1:0]) && b < int'(a[1:0]) + span) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic idle_bus();
    hsel = 1'b0; htrans = 2'd0; hwrite = 1'b0; hsize = 3'd2; haddr = '0;
  endtask

  // One transfer, then wait for its completion; checks R2, R7 and R8.
  task automatic xfer(input logic w, input logic [5:0] a, input logic [2:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd);
    int waits;
    logic quiet;
    @(negedge hclk);
    chk(hreadyout === 1'b1, "R4 ready before address phase", {31'b0, hreadyout}, 32'd1);
    hsel = 1'b1; htrans = 2'd2; hwrite = w; hsize = sz; haddr = {26'b0, a};
    @(negedge hclk);
    idle_bus();
    hwdata = wd;
    waits = 0; quiet = 1'b1;
    while (hreadyout !== 1'b1 && waits < 64) begin
      if (hrdata !== 32'h0) quiet = 1'b0;
      waits++;
      @(negedge hclk);
    end
    rd = hrdata;
    chk(waits == WAIT_N, "R2 wait count", waits, WAIT_N);
    chk(quiet, "R8 rdata zero during waits", {31'b0, quiet}, 32'd1);
    chk(hresp === 1'b0, "R7 response okay", {31'b0, hresp}, 32'd0);
    if (w) model[a[5:2]] = merge(model[a[5:2]], wd, a, sz);
    @(posedge hclk);
  endtask

  task automatic rd_check(input logic [5:0] a, input string req);
    logic [31:0] got;
    xfer(1'b0, a, 3'd2, 32'h0, got);
    chk(got === model[a[5:2]], req, got, model[a[5:2]]);
  endtask

  task automatic wr(input logic [5:0] a, input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] dummy;
    xfer(1'b1, a, sz, d, dummy);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge hclk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] got;
    for (int i = 0; i < DEPTH; i++) model[i] = 32'h0;
    void'($urandom(32'd4242));
    hresetn = 1'b0; other_stall = 1'b0; hwdata = '0;
    idle_bus();
    repeat (3) @(posedge hclk);
    @(negedge hclk);
    hresetn = 1'b1;
    @(negedge hclk);
    // R1: reset state
    chk(hreadyout === 1'b1, "R1 ready after reset", {31'b0, hreadyout}, 32'd1);
    chk(hresp === 1'b0, "R1 okay after reset", {31'b0, hresp}, 32'd0);
    chk(hrdata === 32'h0, "R1 rdata after reset", hrdata, 32'h0);

    // R5: word write then read back
    wr(6'd12, 3'd2, 32'h11223344);
    rd_check(6'd12, "R5 word readback");

    // R6: byte in lane 2 then halfword in lanes 0-1
    wr(6'd14, 3'd0, 32'h00AB0000);
    rd_check(6'd12, "R6 byte merge");
    chk(model[3] === 32'h11AB3344, "R6 byte model", model[3], 32'h11AB3344);
    wr(6'd12, 3'd1, 32'h0000BEEF);
    rd_check(6'd12, "R6 halfword merge");
    chk(model[3] === 32'h11ABBEEF, "R6 halfword model", model[3], 32'h11ABBEEF);

    // R3: selected write while another subordinate stalls the bus
    @(negedge hclk);
    hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; hsize = 3'd2; haddr = 32'd12;
    other_stall = 1'b1;
    @(negedge hclk);
    idle_bus(); other_stall = 1'b0; hwdata = 32'hDEADDEAD;
    for (int k = 0; k < WAIT_N + 1; k++) begin
      chk(hreadyout === 1'b1, "R3 no data phase after stalled request",
          {31'b0, hreadyout}, 32'd1);
      @(negedge hclk);
    end
    @(posedge hclk);
    rd_check(6'd12, "R3 stalled write ignored");

    // R4: IDLE and BUSY while selected, NONSEQ while unselected
    for (int m = 0; m < 3; m++) begin
      @(negedge hclk);
      hsel = (m != 2); htrans = (m == 0) ? 2'd0 : ((m == 1) ? 2'd1 : 2'd2);
      hwrite = 1'b1; hsize = 3'd2; haddr = 32'd12;
      @(negedge hclk);
      idle_bus(); hwdata = 32'hCAFEF00D;
      for (int k = 0; k < 2; k++) begin
        chk(hreadyout === 1'b1, "R4 no stall after inactive cycle",
            {31'b0, hreadyout}, 32'd1);
        @(negedge hclk);
      end
      @(posedge hclk);
    end
    rd_check(6'd12, "R4 inactive writes ignored");

    // R9: read of the same word issued in the write's completing cycle
    @(negedge hclk);
    hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; hsize = 3'd2; haddr = 32'd28;
    @(negedge hclk);
    idle_bus(); hwdata = 32'h0F1E2D3C;
    while (hreadyout !== 1'b1) @(negedge hclk);
    hsel = 1'b1; htrans = 2'd2; hwrite = 1'b0; hsize = 3'd2; haddr = 32'd28;
    model[7] = 32'h0F1E2D3C;
    @(negedge hclk);
    idle_bus();
    chk(hreadyout === 1'b0, "R9 back-to-back phase started", {31'b0, hreadyout}, 32'd0);
    while (hreadyout !== 1'b1) @(negedge hclk);
    got = hrdata;
    chk(got === 32'h0F1E2D3C, "R9 read after write", got, 32'h0F1E2D3C);
    @(posedge hclk);

    // R5 R6: random traffic against the bench model
    for (int n = 0; n < 150; n++) begin
      logic [5:0] a;
      logic [2:0] sz;
      sz = 3'($urandom_range(0, 2));
      a = 6'($urandom_range(0, 63));
      if (sz == 3'd1) a[0] = 1'b0;
      if (sz == 3'd2) a[1:0] = 2'b00;
      if ($urandom_range(0, 1) == 1) wr(a, sz, $urandom());
      else rd_check(a, "R5 R6 random readback");
    end

    summary();
    $finish;
  end

endmodule